// File: doc/BRIEF.md
# Boundary-Pausing System DMA Address Engine

This block produces the byte-address stream of a single-channel system DMA inside a storage host controller. Software programs a 32-bit start address, a block size in bytes, a block count and a 3-bit buffer-boundary code. It then writes a start command. The engine puts out one address beat per cycle in which the downstream side is ready. It counts bytes within each block and counts the blocks down. When the last byte of the last block is taken, it raises a sticky transfer-complete flag and returns to idle.

When boundary handling is enabled, each boundary code selects a contiguous buffer of 4 KiB shifted left by the code, from 4 KiB up to 512 KiB. The engine stops when the next address would carry out of the top in-buffer address bit. It then raises a sticky DMA interrupt and waits. Software writes a fresh start address, and streaming resumes from that address. While a transfer is active, the block configuration register is locked. Reads of it return a fixed invalid pattern, and writes to it are dropped.

Top module: `sdma_addr_engine`

## Requirements
- R1: While streaming, `beat_valid_o` is high and one beat is accepted on each cycle with `beat_ready_i` high. `beat_addr_o` rises by one per accepted beat and holds steady while ready is low.
- R2: A transfer delivers exactly size × count beats. After the last one is accepted, the transfer-complete flag (status bit 1) is set and `busy_o` falls.
- R3: With DMA enable set and boundary code n (buffer 4 KiB << n), accepting a non-final beat whose address has bits [11+n:0] all ones does three things: it sets the DMA interrupt flag (status bit 0), it raises `paused_o`, and it stops all beats.
- R4: If the boundary beat is also the final beat of the transfer, only transfer complete is set. The DMA interrupt stays clear and the engine does not pause.
- R5: With DMA enable clear, streaming passes any boundary without pausing.
- R6: A start with block size 0 or block count 0 produces no beats. It sets transfer complete on the same clock edge, and the engine stays idle.
- R7: While paused, a write to the address register loads that address into the counter. Beats resume from it on the next cycle.
- R8: While busy (streaming or paused), writes to the block configuration register are ignored, and a read of it returns 0x0000_7FFF. When idle, it reads back the value last written while idle.
- R9: After reset every register reads 0 and every output is low. Bit 15 of the configuration register always reads 0.
- R10: The status flags are sticky. Writing 1 to a status bit clears only that bit, and a set on the same edge wins over the clear.
- R11: Register selects are: 0 address, 1 configuration, 2 block count, 3 control, 4 status. The configuration register holds the boundary code in bits [14:12] and the block size in bits [11:0]. The control register holds start in bit 0 and DMA enable in bit 1. Control writes are accepted only when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for the write |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 3 | Register select for the combinational read |
| rd_data_o | output | 32 | Read data |
| beat_valid_o | output | 1 | Address beat valid |
| beat_ready_i | input | 1 | Downstream ready for the beat |
| beat_addr_o | output | 32 | Current byte address |
| busy_o | output | 1 | Transfer active (streaming or paused) |
| paused_o | output | 1 | Halted at a buffer boundary |
| dma_int_o | output | 1 | Sticky DMA interrupt flag |
| xfer_done_o | output | 1 | Sticky transfer-complete flag |

## Verification
The bench builds the engine with its defaults: a 32-bit address, a 12-bit block size, a 16-bit block count and eight boundary codes. Because of the 4 KiB base, small transfers started a few bytes below 0x1000, 0x8000 or 0x80000 reach real boundary carries within a handful of cycles. Those runs cover codes 0, 3 and 7, a crossing that coincides with the final byte, a lower-bit carry that must not pause under code 3, and runs with boundary handling disabled. Backpressure is applied before the first beat, and the configuration lock is probed while paused.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SEL_W  = 3;
  localparam logic [15:0] CFG_INVALID = 16'h7FFF;

  typedef enum logic [SEL_W-1:0] {
    SEL_ADDR = 3'd0,
    SEL_CFG  = 3'd1,
    SEL_CNT  = 3'd2,
    SEL_CTRL = 3'd3,
    SEL_STAT = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/sdma_cfg_regs.sv
module sdma_cfg_regs #(
  parameter int unsigned BSZ_W  = 12,
  parameter int unsigned CODE_W = 3,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              cfg_we_i,
  input  logic [BSZ_W+CODE_W-1:0] cfg_wdata_i,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic              ctrl_we_i,
  input  logic              dma_en_wdata_i,
  output logic [CODE_W-1:0] bnd_code_o,
  output logic [BSZ_W-1:0]  blk_size_o,
  output logic [CNT_W-1:0]  blk_cnt_o,
  output logic              dma_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bnd_code_o <= '0;
      blk_size_o <= '0;
      blk_cnt_o  <= '0;
      dma_en_o   <= 1'b0;
    end else if (!lock_i) begin
      if (cfg_we_i) begin
        bnd_code_o <= cfg_wdata_i[BSZ_W+CODE_W-1:BSZ_W];
        blk_size_o <= cfg_wdata_i[BSZ_W-1:0];
      end
      if (cnt_we_i)  blk_cnt_o <= cnt_wdata_i;
      if (ctrl_we_i) dma_en_o  <= dma_en_wdata_i;
    end
  end
endmodule

// File: rtl/sdma_addr_gen.sv
module sdma_addr_gen #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CODE_W  = 3,
  parameter int unsigned BND_LSB = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              step_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              at_bnd_o
);
  localparam int unsigned NCODE = 1 << CODE_W;

  logic [NCODE-1:0] low_ones;

  // low_ones[k]: next increment carries out of bit BND_LSB-1+k
  for (genvar k = 0; k < NCODE; k++) begin : g_bnd
    assign low_ones[k] = &addr_o[BND_LSB-1+k:0];
  end

  assign at_bnd_o = en_i & low_ones[code_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= load_val_i;
    else if (step_i) addr_o <= addr_o + 1'b1;
  end
endmodule

// File: rtl/sdma_xfer_ctrl.sv
module sdma_xfer_ctrl
  import sdma_pkg::*;
#(
  parameter int unsigned BSZ_W = 12,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BSZ_W-1:0] blk_size_i,
  input  logic [CNT_W-1:0] blk_cnt_i,
  input  logic             at_bnd_i,
  input  logic             ready_i,
  input  logic             addr_wr_i,
  input  logic             clr_int_i,
  input  logic             clr_done_i,
  output logic             valid_o,
  output logic             fire_o,
  output logic             busy_o,
  output logic             paused_o,
  output logic             dma_int_o,
  output logic             done_o
);
  xfer_state_e      state_q;
  logic [BSZ_W-1:0] byte_idx_q;
  logic [CNT_W-1:0] blk_left_q;
  logic last_byte, last_blk, final_beat, empty_cfg, set_int, set_done;

  assign valid_o    = (state_q == ST_RUN);
  assign busy_o     = (state_q != ST_IDLE);
  assign paused_o   = (state_q == ST_HOLD);
  assign fire_o     = valid_o & ready_i;
  assign last_byte  = (byte_idx_q == blk_size_i - 1'b1);
  assign last_blk   = (blk_left_q == {{(CNT_W-1){1'b0}}, 1'b1});
  assign final_beat = fire_o & last_byte & last_blk;
  assign empty_cfg  = (blk_size_i == '0) | (blk_cnt_i == '0);
  // completion outranks the boundary stop
  assign set_int    = fire_o & at_bnd_i & ~final_beat;
  assign set_done   = final_beat | (start_i & empty_cfg);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      byte_idx_q <= '0;
      blk_left_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i && !empty_cfg) begin
          state_q    <= ST_RUN;
          byte_idx_q <= '0;
          blk_left_q <= blk_cnt_i;
        end
        ST_RUN: if (fire_o) begin
          if (last_byte) begin
            byte_idx_q <= '0;
            blk_left_q <= blk_left_q - 1'b1;
          end else begin
            byte_idx_q <= byte_idx_q + 1'b1;
          end
          if (final_beat)   state_q <= ST_IDLE;
          else if (set_int) state_q <= ST_HOLD;
        end
        ST_HOLD: if (addr_wr_i) state_q <= ST_RUN;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_int_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      dma_int_o <= set_int  | (dma_int_o & ~clr_int_i);
      done_o    <= set_done | (done_o & ~clr_done_i);
    end
  end
endmodule

// File: rtl/sdma_addr_engine.sv
module sdma_addr_engine
  import sdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BSZ_W  = 12,
  parameter int unsigned CODE_W = 3,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [31:0]       wr_data_i,
  input  logic [2:0]        rd_sel_i,
  output logic [31:0]       rd_data_o,
  output logic              beat_valid_o,
  input  logic              beat_ready_i,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic              busy_o,
  output logic              paused_o,
  output logic              dma_int_o,
  output logic              xfer_done_o
);
  localparam int unsigned CFG_W   = BSZ_W + CODE_W;
  localparam int unsigned BND_LSB = 12;

  logic [CODE_W-1:0] bnd_code;
  logic [BSZ_W-1:0]  blk_size;
  logic [CNT_W-1:0]  blk_cnt;
  logic dma_en, fire, at_bnd;
  logic we_addr, we_cfg, we_cnt, we_ctrl, we_stat, addr_load, start;

  assign we_addr   = wr_en_i & (wr_sel_i == SEL_ADDR);
  assign we_cfg    = wr_en_i & (wr_sel_i == SEL_CFG);
  assign we_cnt    = wr_en_i & (wr_sel_i == SEL_CNT);
  assign we_ctrl   = wr_en_i & (wr_sel_i == SEL_CTRL);
  assign we_stat   = wr_en_i & (wr_sel_i == SEL_STAT);
  assign addr_load = we_addr & (~busy_o | paused_o);
  assign start     = we_ctrl & wr_data_i[0] & ~busy_o;

  sdma_cfg_regs #(.BSZ_W(BSZ_W), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_cfg (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .lock_i         (busy_o),
    .cfg_we_i       (we_cfg),
    .cfg_wdata_i    (wr_data_i[CFG_W-1:0]),
    .cnt_we_i       (we_cnt),
    .cnt_wdata_i    (wr_data_i[CNT_W-1:0]),
    .ctrl_we_i      (we_ctrl),
    .dma_en_wdata_i (wr_data_i[1]),
    .bnd_code_o     (bnd_code),
    .blk_size_o     (blk_size),
    .blk_cnt_o      (blk_cnt),
    .dma_en_o       (dma_en)
  );

  sdma_addr_gen #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .BND_LSB(BND_LSB)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (addr_load),
    .load_val_i (wr_data_i[ADDR_W-1:0]),
    .step_i     (fire),
    .en_i       (dma_en),
    .code_i     (bnd_code),
    .addr_o     (beat_addr_o),
    .at_bnd_o   (at_bnd)
  );

  sdma_xfer_ctrl #(.BSZ_W(BSZ_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .blk_size_i (blk_size),
    .blk_cnt_i  (blk_cnt),
    .at_bnd_i   (at_bnd),
    .ready_i    (beat_ready_i),
    .addr_wr_i  (addr_load),
    .clr_int_i  (we_stat & wr_data_i[0]),
    .clr_done_i (we_stat & wr_data_i[1]),
    .valid_o    (beat_valid_o),
    .fire_o     (fire),
    .busy_o     (busy_o),
    .paused_o   (paused_o),
    .dma_int_o  (dma_int_o),
    .done_o     (xfer_done_o)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (rd_sel_i)
      SEL_ADDR: rd_data_o[ADDR_W-1:0] = beat_addr_o;
      SEL_CFG:  rd_data_o[15:0] = busy_o ? CFG_INVALID : {{(16-CFG_W){1'b0}}, bnd_code, blk_size};
      SEL_CNT:  rd_data_o[CNT_W-1:0] = blk_cnt;
      SEL_CTRL: rd_data_o[1:0] = {dma_en, 1'b0};
      SEL_STAT: rd_data_o[1:0] = {xfer_done_o, dma_int_o};
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/sdma_addr_engine_checks.sv
module sdma_addr_engine_checks (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        beat_valid_o,
  input logic        beat_ready_i,
  input logic [31:0] beat_addr_o,
  input logic        busy_o,
  input logic        paused_o,
  input logic        dma_int_o,
  input logic        xfer_done_o
);
  assert_hold_beat_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_addr_o));

  assert_addr_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && beat_ready_i |=> beat_addr_o == $past(beat_addr_o) + 32'd1);

  assert_int_pauses_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_int_o) |-> paused_o);

  assert_pause_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_o |-> !beat_valid_o && busy_o);

  assert_done_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xfer_done_o) |-> !busy_o && !$rose(dma_int_o));
endmodule

bind sdma_addr_engine sdma_addr_engine_checks u_checks (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .beat_valid_o (beat_valid_o),
  .beat_ready_i (beat_ready_i),
  .beat_addr_o  (beat_addr_o),
  .busy_o       (busy_o),
  .paused_o     (paused_o),
  .dma_int_o    (dma_int_o),
  .xfer_done_o  (xfer_done_o)
);

// File: tb/sim_sdma_addr_engine.sv
module sim_sdma_addr_engine;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [2:0] R_ADDR = 3'd0, R_CFG = 3'd1, R_CNT = 3'd2, R_CTRL = 3'd3, R_STAT = 3'd4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 1'b0, ready = 1'b1;
  logic [2:0] wr_sel = '0, rd_sel = '0;
  logic [31:0] wr_data = '0, rd_data, beat_addr;
  logic beat_valid, busy, paused, dma_int, xfer_done;

  int checks = 0, fails = 0, beat_cnt = 0, addr_err = 0;
  logic [31:0] exp_next = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdma_addr_engine u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .beat_valid_o(beat_valid), .beat_ready_i(ready), .beat_addr_o(beat_addr),
    .busy_o(busy), .paused_o(paused), .dma_int_o(dma_int), .xfer_done_o(xfer_done)
  );

  // beat monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (beat_valid && ready) begin
      if (beat_addr !== exp_next) addr_err++;
      beat_cnt++;
      exp_next = exp_next + 32'd1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] data);
    rd_sel = sel; #1; data = rd_data;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
  endtask

  task automatic wait_pause();
    for (int i = 0; i < 4000 && !paused && busy; i++) @(negedge clk);
  endtask

  task automatic launch(input logic [31:0] addr, input logic [15:0] cfg,
                        input logic [15:0] cnt, input logic en);
    wr(R_STAT, 32'h3);
    wr(R_ADDR, addr);
    wr(R_CFG, {16'h0, cfg});
    wr(R_CNT, {16'h0, cnt});
    beat_cnt = 0; addr_err = 0; exp_next = addr;
    wr(R_CTRL, {30'h0, en, 1'b1});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int s = 0; s < 5; s++) begin
      rd(s[2:0], v);
      chk("R9 reset register", v, 32'h0);
    end
    chk("R9 reset outputs", {28'h0, beat_valid, busy, dma_int, xfer_done}, 32'h0);
  endtask

  task automatic t_plain();
    launch(32'h1000_0000, 16'h0004, 16'd3, 1'b0);
    wait_idle();
    chk("R2 beat total", beat_cnt, 32'd12);
    chk("R1 address sequence", addr_err, 0);
    chk("R2 done flag", {30'h0, xfer_done, dma_int}, 32'h2);
  endtask

  task automatic t_bnd_code0();
    logic [31:0] v;
    launch(32'h0000_0FFC, 16'h0008, 16'd1, 1'b1);
    wait_pause();
    @(negedge clk);
    chk("R3 beats before pause", beat_cnt, 32'd4);
    chk("R3 paused with int", {29'h0, paused, beat_valid, dma_int}, 32'h5);
    chk("R3 address parked at boundary", beat_addr, 32'h0000_1000);
    wr(R_CFG, 32'h0000_0123);
    rd(R_CFG, v);
    chk("R8 invalid read while busy", v, 32'h0000_7FFF);
    wr(R_STAT, 32'h1);
    chk("R10 w1c clears int only", {30'h0, xfer_done, dma_int}, 32'h0);
    exp_next = 32'h2000_0000;
    wr(R_ADDR, 32'h2000_0000);
    chk("R7 resumes from new address", {beat_valid, beat_addr[30:0]}, {1'b1, 31'h2000_0000});
    wait_idle();
    chk("R7 beat total after resume", beat_cnt, 32'd8);
    chk("R7 address sequence", addr_err, 0);
    chk("R2 done, no int", {30'h0, xfer_done, dma_int}, 32'h2);
    rd(R_CFG, v);
    chk("R8 locked write dropped", v, 32'h0000_0008);
  endtask

  task automatic t_bnd_code3();
    launch(32'h0000_6FFE, 16'h3004, 16'd1, 1'b1);
    wait_idle();
    chk("R3 code3 ignores bit11 carry", {beat_cnt[15:0], 14'h0, dma_int, xfer_done}, {16'd4, 16'h1});
    launch(32'h0000_7FFE, 16'h3004, 16'd1, 1'b1);
    wait_pause();
    @(negedge clk);
    chk("R3 code3 pause at 32K", {beat_cnt[15:0], 15'h0, paused}, {16'd2, 16'h1});
    exp_next = 32'h0009_0000;
    wr(R_ADDR, 32'h0009_0000);
    wait_idle();
    chk("R7 code3 resume total", {beat_cnt[15:0], addr_err[15:0]}, {16'd4, 16'd0});
  endtask

  task automatic t_bnd_code7();
    launch(32'h0007_FFFF, 16'h7004, 16'd1, 1'b1);
    wait_pause();
    @(negedge clk);
    chk("R3 code7 pause at 512K", {beat_cnt[15:0], 14'h0, paused, dma_int}, {16'd1, 16'h3});
    exp_next = 32'h0010_0000;
    wr(R_ADDR, 32'h0010_0000);
    wait_idle();
    chk("R7 code7 resume total", {beat_cnt[15:0], addr_err[15:0]}, {16'd4, 16'd0});
  endtask

  task automatic t_bnd_at_end();
    launch(32'h0000_0FFC, 16'h0004, 16'd1, 1'b1);
    wait_idle();
    @(negedge clk);
    chk("R4 end on boundary", {beat_cnt[15:0], 13'h0, paused, xfer_done, dma_int}, {16'd4, 16'h2});
  endtask

  task automatic t_no_dma_en();
    launch(32'h0000_0FFE, 16'h0004, 16'd2, 1'b0);
    wait_idle();
    chk("R5 no pause when disabled", {beat_cnt[15:0], 14'h0, xfer_done, dma_int}, {16'd8, 16'h2});
    chk("R5 address sequence", addr_err, 0);
  endtask

  task automatic t_empty();
    launch(32'h0000_0100, 16'h0000, 16'd2, 1'b0);
    chk("R6 zero size done at once", {29'h0, busy, xfer_done, beat_valid}, 32'h2);
    launch(32'h0000_0100, 16'h0004, 16'd0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R6 zero count no beats", {beat_cnt[15:0], 14'h0, busy, xfer_done}, {16'd0, 16'h1});
  endtask

  task automatic t_backpressure();
    ready = 1'b0;
    launch(32'h0000_0200, 16'h0006, 16'd1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1 held while not ready", {beat_cnt[15:0], 15'h0, beat_valid}, {16'd0, 16'h1});
    chk("R1 address stable", beat_addr, 32'h0000_0200);
    for (int i = 0; i < 40 && busy; i++) begin
      @(posedge clk); #1; ready = ~ready;
    end
    ready = 1'b1;
    wait_idle();
    chk("R1 total under backpressure", {beat_cnt[15:0], addr_err[15:0]}, {16'd6, 16'd0});
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(R_CFG, 32'h0000_B234);
    rd(R_CFG, v);
    chk("R9 reserved bit15 zero", v, 32'h0000_3234);
    wr(R_CTRL, 32'h2);
    rd(R_CTRL, v);
    chk("R11 control enable bit", v, 32'h2);
    rd(R_STAT, v);
    chk("R10 done sticky", v, 32'h2);
    wr(R_STAT, 32'h2);
    rd(R_STAT, v);
    chk("R10 w1c clears done", v, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_bnd_code0();
    t_bnd_code3();
    t_bnd_code7();
    t_bnd_at_end();
    t_no_dma_en();
    t_empty();
    t_backpressure();
    t_regs();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule